// File: doc/BRIEF.md
# Single-Precision NaN Propagation Unit

This combinational unit sits beside a single-precision floating-point datapath and handles the NaN cases of an operation. It classifies each 32-bit operand, decides whether a signalling NaN must raise the invalid-operation exception, and forms the NaN word the operation returns. It works in one-operand or two-operand mode. In one-operand mode the second operand is ignored.

The unit follows the older convention in which a **set** top mantissa bit (bit 22) marks a signalling NaN. Quieting therefore clears that bit. If clearing it would leave an all-zero mantissa, the word would read as infinity, so a fixed default NaN is returned instead. When two NaNs compete, the one with the larger 23-bit mantissa wins. Sign plays no part in that choice, and a tie goes to the second operand. When the invalid exception is trap-enabled, the unit requests a trap and passes the NaN through untouched.

The block has no clock and no state, so there are no states or transitions to name. Every output is a pure function of the present inputs.

Top module: `sp_nan_unit`

## Requirements
- R1: Each operand is classified on a 3-bit code: zero=0, normal=1, denormal=2, infinity=3, signalling NaN=4, quiet NaN=5. A class code of 4 or more means NaN.
- R2: A NaN (exponent all ones, mantissa non-zero) is signalling when mantissa bit 22 is 1, and quiet when bit 22 is 0.
- R3: A quiet NaN operand raises no invalid flag and no trap, and is returned unchanged, whatever the trap enable.
- R4: A chosen signalling NaN with the trap disabled sets the invalid flag. The result is that NaN with bit 22 cleared.
- R5: If clearing bit 22 leaves a zero mantissa, the result is 0x7FBFFFFF, whatever the operand's sign.
- R6: A signalling NaN with the trap enabled sets both the invalid flag and the trap request. The result is the NaN unmodified.
- R7: In two-operand mode with both operands NaN, the result comes from the operand whose 23-bit mantissa is numerically larger, and the sign is ignored. On equal mantissas the second operand is taken.
- R8: In two-operand mode with exactly one NaN operand, the result comes from that operand. A signalling NaN in either position raises the invalid flag.
- R9: In one-operand mode the second operand has no effect on the result, the NaN indication, the invalid flag or the trap request.
- R10: With no NaN among the considered operands, the NaN indication, the invalid flag and the trap request are 0 and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (used only in two-operand mode) |
| dual_i | input | 1 | 1 = two-operand mode, 0 = one-operand mode |
| trap_en_i | input | 1 | Invalid-operation trap enable |
| cls_a_o | output | 3 | Class code of the first operand |
| cls_b_o | output | 3 | Class code of the second operand |
| nan_hit_o | output | 1 | A considered operand is a NaN, so result_o is valid |
| result_o | output | 32 | Propagated NaN word, or zero when nan_hit_o is 0 |
| invalid_set_o | output | 1 | Request to set the sticky invalid-operation flag |
| trap_req_o | output | 1 | Invalid-operation trap request |

## Verification
The bench builds the unit with its default widths: an 8-bit exponent and a 23-bit mantissa. Only at those widths do the expected constants (0x7FBFFFFF, bit 22, the chosen NaN patterns) hold. This brings the exact single-precision edge cases within reach:
- a signalling NaN whose only mantissa bit is bit 22, which would quiet to infinity;
- mantissa ties between operands of opposite sign;
- a quiet NaN competing against a signalling NaN in either position.

// File: rtl/nanu_pkg.sv
package nanu_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_NORM   = 3'd1,
        CLS_DENORM = 3'd2,
        CLS_INF    = 3'd3,
        CLS_SNAN   = 3'd4,
        CLS_QNAN   = 3'd5
    } fp_class_e;

endpackage

// File: rtl/nanu_classify.sv
module nanu_classify
    import nanu_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] word_i,
    output fp_class_e            cls_o,
    output logic                 is_nan_o,
    output logic                 is_snan_o
);
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;

    assign expo = word_i[EXP_W+MAN_W-1:MAN_W];
    assign mant = word_i[MAN_W-1:0];

    always_comb begin
        if (&expo) begin
            if (mant == '0)          cls_o = CLS_INF;
            else if (mant[MAN_W-1])  cls_o = CLS_SNAN;
            else                     cls_o = CLS_QNAN;
        end else if (expo == '0) begin
            cls_o = (mant == '0) ? CLS_ZERO : CLS_DENORM;
        end else begin
            cls_o = CLS_NORM;
        end
    end

    // Ordering of the class codes lets one compare detect any NaN.
    assign is_nan_o  = (cls_o >= CLS_SNAN);
    assign is_snan_o = (cls_o == CLS_SNAN);

    always_comb begin
        AST_CLASS_IN_RANGE: assert (cls_o <= CLS_QNAN) else $error("class code out of range"); // R1
    end

endmodule

// File: rtl/nanu_quiet.sv
module nanu_quiet #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] word_i,
    input  logic                 snan_i,
    input  logic                 trap_en_i,
    output logic [EXP_W+MAN_W:0] word_o
);
    localparam int W = EXP_W + MAN_W + 1;
    localparam logic [W-1:0] QBIT_MASK = W'(1) << (MAN_W - 1);
    localparam logic [W-1:0] DEF_NAN   = {1'b0, {EXP_W{1'b1}}, 1'b0, {(MAN_W-1){1'b1}}};

    logic [W-1:0] cleared;

    assign cleared = word_i & ~QBIT_MASK;

    always_comb begin
        if (snan_i && !trap_en_i) begin
            word_o = (cleared[MAN_W-1:0] == '0) ? DEF_NAN : cleared;
        end else begin
            word_o = word_i;
        end
    end

endmodule

// File: rtl/sp_nan_unit.sv
module sp_nan_unit
    import nanu_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    input  logic        dual_i,
    input  logic        trap_en_i,
    output logic [2:0]  cls_a_o,
    output logic [2:0]  cls_b_o,
    output logic        nan_hit_o,
    output logic [31:0] result_o,
    output logic        invalid_set_o,
    output logic        trap_req_o
);
    localparam int W      = EXP_W + MAN_W + 1;
    localparam int N_OPS  = 2;

    logic [W-1:0] ops     [N_OPS];
    fp_class_e    cls     [N_OPS];
    logic         is_nan  [N_OPS];
    logic         is_snan [N_OPS];

    assign ops[0] = W'(opa_i);
    assign ops[1] = W'(opb_i);

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        nanu_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .word_i    (ops[gi]),
            .cls_o     (cls[gi]),
            .is_nan_o  (is_nan[gi]),
            .is_snan_o (is_snan[gi])
        );
    end

    assign cls_a_o = cls[0];
    assign cls_b_o = cls[1];

    logic         a_live, b_live, pick_b, chosen_snan;
    logic [W-1:0] chosen, quieted;

    always_comb begin
        a_live = is_nan[0];
        b_live = dual_i && is_nan[1];
        if (a_live && b_live) begin
            pick_b = !(ops[0][MAN_W-1:0] > ops[1][MAN_W-1:0]);
        end else begin
            pick_b = b_live;
        end
        chosen      = pick_b ? ops[1] : ops[0];
        chosen_snan = pick_b ? is_snan[1] : is_snan[0];
    end

    nanu_quiet #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_quiet (
        .word_i    (chosen),
        .snan_i    (chosen_snan),
        .trap_en_i (trap_en_i),
        .word_o    (quieted)
    );

    assign nan_hit_o     = a_live || b_live;
    assign invalid_set_o = (a_live && is_snan[0]) || (b_live && is_snan[1]);
    assign trap_req_o    = invalid_set_o && trap_en_i;
    assign result_o      = nan_hit_o ? 32'(quieted) : '0;

    always_comb begin
        AST_TRAP_NEEDS_INVALID: assert (!trap_req_o || invalid_set_o) else $error("trap without invalid"); // R6
        AST_RESULT_IS_NAN: assert (!nan_hit_o || ((&result_o[EXP_W+MAN_W-1:MAN_W]) && (result_o[MAN_W-1:0] != '0))) else $error("NaN result not a NaN"); // R5
        AST_UNTRAPPED_QUIET: assert (!nan_hit_o || trap_req_o || !result_o[MAN_W-1]) else $error("untrapped result still signalling"); // R4
        AST_INVALID_NEEDS_NAN: assert (!invalid_set_o || nan_hit_o) else $error("invalid without NaN"); // R10
    end

endmodule

// File: tb/tb_sp_nan_unit.sv
module tb_sp_nan_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [31:0] opa, opb;
    logic        dual, trap_en;
    logic [2:0]  cls_a, cls_b;
    logic        nan_hit, inv, trap;
    logic [31:0] res;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_nan_unit dut (
        .opa_i(opa), .opb_i(opb), .dual_i(dual), .trap_en_i(trap_en),
        .cls_a_o(cls_a), .cls_b_o(cls_b), .nan_hit_o(nan_hit),
        .result_o(res), .invalid_set_o(inv), .trap_req_o(trap)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic d, input logic t);
        @(negedge clk);
        opa = a; opb = b; dual = d; trap_en = t;
        #(CLK_PERIOD/4);
    endtask

    task automatic expect_out(input string tag, input logic h, input logic [31:0] r,
                              input logic i, input logic tr);
        chk({tag, " nan_hit"}, 32'(nan_hit), 32'(h));
        chk({tag, " result"},  res, r);
        chk({tag, " invalid"}, 32'(inv), 32'(i));
        chk({tag, " trap"},    32'(trap), 32'(tr));
    endtask

    task automatic t_idle();
        drive(32'h0, 32'h0, 1'b0, 1'b0);
        chk("R1 zero class", 32'(cls_a), 32'd0);
        expect_out("R10 idle", 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_classes();
        drive(32'h3F80_0000, 32'h0000_0001, 1'b0, 1'b0);
        chk("R1 normal", 32'(cls_a), 32'd1);
        chk("R1 denormal", 32'(cls_b), 32'd2);
        drive(32'h7F80_0000, 32'h7FC0_0001, 1'b0, 1'b0);
        chk("R1 infinity", 32'(cls_a), 32'd3);
        chk("R2 signalling", 32'(cls_b), 32'd4);
        drive(32'h7F80_0001, 32'hFFC0_0000, 1'b0, 1'b0);
        chk("R2 quiet", 32'(cls_a), 32'd5);
        chk("R2 signalling neg", 32'(cls_b), 32'd4);
    endtask

    task automatic t_quiet_pass();
        drive(32'h7F81_2345, 32'h0, 1'b0, 1'b1);
        expect_out("R3 qnan trap on", 1'b1, 32'h7F81_2345, 1'b0, 1'b0);
        drive(32'hFF80_0001, 32'h0, 1'b0, 1'b0);
        expect_out("R3 qnan trap off", 1'b1, 32'hFF80_0001, 1'b0, 1'b0);
    endtask

    task automatic t_quieting();
        drive(32'hFFC0_1234, 32'h0, 1'b0, 1'b0);
        expect_out("R4 quiet", 1'b1, 32'hFF80_1234, 1'b1, 1'b0);
    endtask

    task automatic t_default();
        drive(32'h7FC0_0000, 32'h0, 1'b0, 1'b0);
        expect_out("R5 default pos", 1'b1, 32'h7FBF_FFFF, 1'b1, 1'b0);
        drive(32'hFFC0_0000, 32'h0, 1'b0, 1'b0);
        expect_out("R5 default neg", 1'b1, 32'h7FBF_FFFF, 1'b1, 1'b0);
    endtask

    task automatic t_trap();
        drive(32'h7FC0_0005, 32'h0, 1'b0, 1'b1);
        expect_out("R6 trap", 1'b1, 32'h7FC0_0005, 1'b1, 1'b1);
        drive(32'h7FC0_0000, 32'h0, 1'b0, 1'b1);
        expect_out("R6 trap bare", 1'b1, 32'h7FC0_0000, 1'b1, 1'b1);
    endtask

    task automatic t_two_nans();
        drive(32'h7F80_0010, 32'h7F80_0020, 1'b1, 1'b0);
        expect_out("R7 b larger", 1'b1, 32'h7F80_0020, 1'b0, 1'b0);
        drive(32'h7F80_0030, 32'hFF80_0020, 1'b1, 1'b0);
        expect_out("R7 a larger", 1'b1, 32'h7F80_0030, 1'b0, 1'b0);
        drive(32'h7F80_0040, 32'hFF80_0040, 1'b1, 1'b0);
        expect_out("R7 tie", 1'b1, 32'hFF80_0040, 1'b0, 1'b0);
        drive(32'h7FC0_0001, 32'h7F80_0002, 1'b1, 1'b0);
        expect_out("R7 snan wins", 1'b1, 32'h7F80_0001, 1'b1, 1'b0);
    endtask

    task automatic t_one_nan();
        drive(32'h3F80_0000, 32'h7F80_0007, 1'b1, 1'b0);
        expect_out("R8 b only", 1'b1, 32'h7F80_0007, 1'b0, 1'b0);
        drive(32'h7FC0_0009, 32'h3F80_0000, 1'b1, 1'b0);
        expect_out("R8 a only snan", 1'b1, 32'h7F80_0009, 1'b1, 1'b0);
        drive(32'h7F80_0005, 32'h7FC0_0001, 1'b1, 1'b0);
        expect_out("R8 snan in b", 1'b1, 32'h7F80_0001, 1'b1, 1'b0);
    endtask

    task automatic t_single_ignores_b();
        drive(32'h3F80_0000, 32'h7FC0_0001, 1'b0, 1'b1);
        expect_out("R9 b ignored", 1'b0, 32'h0, 1'b0, 1'b0);
        drive(32'h7F80_0003, 32'h7FC0_1000, 1'b0, 1'b0);
        expect_out("R9 a kept", 1'b1, 32'h7F80_0003, 1'b0, 1'b0);
    endtask

    task automatic t_no_nan();
        drive(32'h4000_0000, 32'hFF80_0000, 1'b1, 1'b1);
        expect_out("R10 numbers", 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    initial begin
        opa = '0; opb = '0; dual = 1'b0; trap_en = 1'b0;
        t_idle();
        t_classes();
        t_quiet_pass();
        t_quieting();
        t_default();
        t_trap();
        t_two_nans();
        t_one_nan();
        t_single_ignores_b();
        t_no_nan();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule